// File: doc/BRIEF.md
# Interrupt Request Flag Register Bank

This block gathers interrupt request flags from five external request pins and from several on-chip event sources into two 8-bit registers that the processor reads and writes over a small bus (register select, write enable, write data, read data). Each flag is latched by a one-cycle event pulse or by a detected pin edge. The flag stays latched until software clears it explicitly. Accepting the interrupt elsewhere in the chip does not clear it.

Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag unchanged, so a read-modify-write cannot lose a pending request. The timer-Y flag cannot be written directly. It is cleared by writing 0 to a separate write-only strobe bit in the same register.

Each request pin passes through a synchronizer. Its edge polarity and its use as an interrupt input are selected per pin. A combined request output is high while any flag is set.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, register 0 (addr_i=0) reads 8'hA0 and register 1 (addr_i=1) reads 8'h21. irq_o is 0.
- R2: An event pulse sets its flag, which reads 1 on the cycle after the pulse. The flag positions are: serial_done_i at register 0 bit 6; dxfer_req_i at register 1 bit 7; adc_req_i at register 1 bit 6; tmr_g_req_i at register 1 bit 4; tmr_fh_req_i at register 1 bit 3; tmr_fl_req_i at register 1 bit 2; tmr_y_req_i at register 1 bit 1.
- R3: A set flag stays set for as long as no clearing write reaches it.
- R4: A write of 0 to a writable flag bit clears that flag on the next cycle. A write of 1 leaves the flag unchanged.
- R5: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Register 0 bits 7 and 5, and register 1 bits 5 and 0, always read 1, and writes do not change them.
- R7: Writing 0 to register 1 bit 1 does not clear the timer-Y flag. Writing 0 to register 1 bit 0 clears it.
- R8: Pin flag n is register 0 bit n, for n from 0 to 4. When pin_en_i[n]=1, the flag is set by the edge chosen by edge_sel_i[n] (1 = rising, 0 = falling). The flag reads 1 three clock edges after the pin changes and still reads 0 after two. The opposite edge does not set it.
- R9: While pin_en_i[n]=0, edges on pin n do not set flag n.
- R10: irq_o is 1 exactly when at least one flag is set.
- R11: A write updates only the register selected by addr_i. The other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 = pin/serial register, 1 = peripheral register |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data; a 0 bit clears the matching flag |
| rdata_o | output | 8 | Read data of the selected register |
| irq_pin_i | input | 5 | Asynchronous external request pins |
| pin_en_i | input | 5 | Per-pin interrupt-input enable |
| edge_sel_i | input | 5 | Per-pin edge select, 1 = rising, 0 = falling |
| serial_done_i | input | 1 | Serial transfer complete pulse |
| dxfer_req_i | input | 1 | Direct-transfer request pulse |
| adc_req_i | input | 1 | ADC request pulse |
| tmr_g_req_i | input | 1 | Timer G request pulse |
| tmr_fh_req_i | input | 1 | Timer FH request pulse |
| tmr_fl_req_i | input | 1 | Timer FL request pulse |
| tmr_y_req_i | input | 1 | Timer Y request pulse |
| irq_o | output | 1 | OR of all flags |

## Verification
The bench sweeps every event source through set, hold, write-1 and write-0 phases. A design that cleared on writes of 1, or cleared on its own, would show a flag missing. A clear that lands in the same cycle as its set event is checked, because a design with the wrong priority drops that request. The timer-Y flag is written through the wrong bit and then through the strobe bit, to catch a design that lets either bit clear it or lets neither clear it. Every pin is swept over both polarities and both enable states, with latency sampled at two and three edges. This catches a missing synchronizer stage, inverted polarity, or enable gating that is absent.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_PINS = 5;

  // register 0: serial flag at bit 6, pin flags at bits 4:0
  localparam logic [REG_W-1:0] REG0_FLAGS = 8'b0101_1111;
  localparam logic [REG_W-1:0] REG0_CONST = 8'b1010_0000;
  // register 1: bits 7,6,4,3,2 writable flags, bit 1 strobe-cleared flag
  localparam logic [REG_W-1:0] REG1_FLAGS = 8'b1101_1110;
  localparam logic [REG_W-1:0] REG1_CONST = 8'b0010_0001;

  localparam int SER_BIT  = 6;
  localparam int TY_BIT   = 1;
  localparam int TY_STRB  = 0;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur   = sync_q[SYNC_STAGES-1];
  assign hit_o = en_i & (rise_sel_i ? (cur & ~prev_q) : (~cur & prev_q));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int                 W         = 8,
  parameter logic [W-1:0]       FLAG_MASK = '0,
  parameter logic [W-1:0]       CONST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] rd_o,
  output logic         pend_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;  // set wins over clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign rd_o[i] = q;
    end else begin : g_const
      logic unused_bit;
      assign unused_bit = set_i[i] | clr_i[i];
      assign rd_o[i]    = CONST_VAL[i];
    end
  end

  assign pend_o = |(rd_o & FLAG_MASK);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic [NUM_PINS-1:0] edge_sel_i,
  input  logic                serial_done_i,
  input  logic                dxfer_req_i,
  input  logic                adc_req_i,
  input  logic                tmr_g_req_i,
  input  logic                tmr_fh_req_i,
  input  logic                tmr_fl_req_i,
  input  logic                tmr_y_req_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_hit;
  logic [REG_W-1:0]    set_a, set_b, clr_a, clr_b, rd_a, rd_b;
  logic                pend_a, pend_b, wr_a, wr_b;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (irq_pin_i[n]),
      .en_i       (pin_en_i[n]),
      .rise_sel_i (edge_sel_i[n]),
      .hit_o      (pin_hit[n])
    );
  end

  assign wr_a = we_i & ~addr_i;
  assign wr_b = we_i &  addr_i;

  always_comb begin
    set_a                   = '0;
    set_a[NUM_PINS-1:0]     = pin_hit;
    set_a[SER_BIT]          = serial_done_i;
    set_b                   = {dxfer_req_i, adc_req_i, 1'b0, tmr_g_req_i,
                               tmr_fh_req_i, tmr_fl_req_i, tmr_y_req_i, 1'b0};
    clr_a                   = {REG_W{wr_a}} & ~wdata_i;
    clr_b                   = {REG_W{wr_b}} & ~wdata_i;
    // timer Y flag is cleared only through its strobe bit
    clr_b[TY_BIT]           = wr_b & ~wdata_i[TY_STRB];
  end

  irq_flag_reg #(.W(REG_W), .FLAG_MASK(REG0_FLAGS), .CONST_VAL(REG0_CONST)) u_reg0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_a),
    .clr_i  (clr_a),
    .rd_o   (rd_a),
    .pend_o (pend_a)
  );

  irq_flag_reg #(.W(REG_W), .FLAG_MASK(REG1_FLAGS), .CONST_VAL(REG1_CONST)) u_reg1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_b),
    .clr_i  (clr_b),
    .rd_o   (rd_b),
    .pend_o (pend_b)
  );

  assign rdata_o = addr_i ? rd_b : rd_a;
  assign irq_o   = pend_a | pend_b;
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk
  import irq_flag_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                addr_i,
  input logic                we_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [NUM_PINS-1:0] pin_en_i,
  input logic                serial_done_i,
  input logic                tmr_y_req_i,
  input logic                irq_o,
  input logic [REG_W-1:0]    rd_a,
  input logic [REG_W-1:0]    rd_b
);
  logic wr_a, wr_b;
  assign wr_a = we_i & ~addr_i;
  assign wr_b = we_i &  addr_i;

  assert_reserved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_a & REG0_CONST) == REG0_CONST) && ((rd_b & REG1_CONST) == REG1_CONST));

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_done_i |=> rd_a[SER_BIT]);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a[SER_BIT] && !(wr_a && !wdata_i[SER_BIT]) |=> rd_a[SER_BIT]);

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a && !wdata_i[SER_BIT] && !serial_done_i |=> !rd_a[SER_BIT]);

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b && !wdata_i[TY_STRB] && tmr_y_req_i |=> rd_b[TY_BIT]);

  assert_ty_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b && !wdata_i[TY_STRB] && !tmr_y_req_i |=> !rd_b[TY_BIT]);

  assert_irq_or_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(rd_a & REG0_FLAGS) || |(rd_b & REG1_FLAGS)));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
    assert_pin_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_a[n]) |-> $past(pin_en_i[n]));
  end
endmodule

bind irq_flag_bank irq_flag_bank_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .we_i          (we_i),
  .wdata_i       (wdata_i),
  .pin_en_i      (pin_en_i),
  .serial_done_i (serial_done_i),
  .tmr_y_req_i   (tmr_y_req_i),
  .irq_o         (irq_o),
  .rd_a          (rd_a),
  .rd_b          (rd_b)
);

// File: tb/irq_flag_bank_bench.sv
module irq_flag_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] pin = '0, pin_en = '0, esel = '0;
  logic [6:0] src = '0;  // {dx, adc, g, fh, fl, ty, serial}
  logic       irq;

  int checks = 0, fails = 0;
  logic [7:0] ea = 8'h00, eb = 8'h00;  // expected flag bits

  always #2.5 clk = ~clk;

  irq_flag_bank u_irq_flag_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_pin_i(pin), .pin_en_i(pin_en), .edge_sel_i(esel),
    .serial_done_i(src[0]), .dxfer_req_i(src[6]), .adc_req_i(src[5]),
    .tmr_g_req_i(src[4]), .tmr_fh_req_i(src[3]), .tmr_fl_req_i(src[2]),
    .tmr_y_req_i(src[1]), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic a);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, a ? (8'h21 | eb) : (8'hA0 | ea));
    chk({req, " R10 irq"}, {7'd0, irq}, {7'd0, (ea != 0) || (eb != 0)});
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [6:0] s);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; src = s;
    @(negedge clk); we = 1'b0; src = '0;
  endtask

  function automatic int src_pos(input int k, output logic r1);
    int p[7] = '{6, 1, 2, 3, 4, 6, 7};
    r1 = (k != 0);
    return p[k];
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 reset reg0", 1'b0);
    rd("R1 reset reg1", 1'b1);

    // R6: attempt to clear reserved/strobe bits
    wr(1'b0, 8'h00, '0); rd("R6 reg0 after zero write", 1'b0);
    wr(1'b1, 8'h00, '0); rd("R6 reg1 after zero write", 1'b1);

    // internal sources sweep
    for (int k = 0; k < 7; k++) begin
      logic r1;
      int   p;
      p = src_pos(k, r1);
      @(negedge clk); src = 7'(1 << k);
      @(negedge clk); src = '0;
      if (r1) eb[p] = 1'b1; else ea[p] = 1'b1;
      rd("R2 source sets flag", r1);
      repeat (5) @(negedge clk);
      rd("R3 flag holds", r1);
      wr(r1, 8'hFF, '0);
      rd("R4 write one keeps flag", r1);
      wr(!r1, 8'h00, '0);
      rd("R11 other register write", r1);
      if (k == 1) begin
        wr(1'b1, 8'hFD, '0);
        rd("R7 bit1 write does not clear", 1'b1);
        wr(1'b1, 8'hFE, '0);
        eb[p] = 1'b0;
        rd("R7 strobe clears", 1'b1);
      end else begin
        wr(r1, ~(8'(1) << p), '0);
        if (r1) eb[p] = 1'b0; else ea[p] = 1'b0;
        rd("R4 write zero clears", r1);
      end
    end

    // R5: set and clear collide
    wr(1'b0, 8'h00, 7'b000_0001); ea[6] = 1'b1;
    rd("R5 set wins reg0", 1'b0);
    wr(1'b1, 8'h00, 7'b100_0010); eb[7] = 1'b1; eb[1] = 1'b1;
    rd("R5 set wins reg1", 1'b1);
    wr(1'b0, 8'h00, '0); wr(1'b1, 8'h00, '0);
    ea = 0; eb = 0;
    rd("R4 bulk clear reg0", 1'b0);
    rd("R4 bulk clear reg1", 1'b1);

    // pin sweep
    for (int n = 0; n < 5; n++) begin
      for (int s = 0; s < 2; s++) begin
        for (int e = 0; e < 2; e++) begin
          @(negedge clk); pin_en = '0; esel = '0; esel[n] = s[0];
          pin[n] = ~s[0];
          repeat (5) @(negedge clk);
          wr(1'b0, 8'h00, '0); ea = 0;
          @(negedge clk); addr = 1'b0; pin_en[n] = e[0];
          pin[n] = s[0];
          @(posedge clk); @(posedge clk);
          rd(e ? "R8 no flag after two edges" : "R9 disabled pin", 1'b0);
          ea[n] = e[0];
          rd(e ? "R8 flag after three edges" : "R9 disabled pin", 1'b0);
          wr(1'b0, 8'h00, '0); ea = 0;
          @(negedge clk); pin[n] = ~s[0];
          repeat (5) @(negedge clk);
          rd("R8 opposite edge ignored", 1'b0);
        end
      end
      @(negedge clk); pin[n] = 1'b0; pin_en = '0;
      repeat (5) @(negedge clk);
      wr(1'b0, 8'h00, '0); ea = 0;
    end
    rd("R1 idle end reg0", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule